// File: doc/BRIEF.md
# Bridge Read Prefetch Request Scheduler

This block decides how many 64-byte cache lines a bridge asks for on behalf of a delayed PCI read, and when it asks for them. Two 16-bit parameter registers, one for 33 MHz and one for 66 MHz operation, each hold four 4-bit size fields. Every size is 0-based, so a field value of n stands for n+1 lines. A speed-select input picks the register whose fields are copied into a working set at the start of each transaction. The working set stays fixed for the rest of that transaction.

A prefetchable read starts with one initial request. Delivery to the PCI master is held off until enough lines have arrived. While the master drains the buffer, a low fill level triggers a follow-up request. Follow-up requests are paced by a delay counter, which is loaded from the subsequent-request field with three ones placed above it. A plain memory read fetches exactly one line. It ends when that line drains, and it never fetches again. The fill count never exceeds the buffer capacity, and each request is trimmed to the free space.

Top module: `pf_sched`

## Requirements
- R1: After reset, the 33 MHz register reads 16'h1212 and the 66 MHz register reads 16'h3323. `cfg_sel`=0 addresses the 33 MHz register and `cfg_sel`=1 the 66 MHz register. A write with `cfg_we` replaces the addressed register. The field layout is: subsequent threshold in bits 15:12, subsequent request in bits 11:8, initial threshold in bits 7:4, initial request in bits 3:0.
- R2: When `txn_start` is seen in idle with `txn_pref`=1, `req_valid` pulses one cycle later with `req_lines` equal to the initial-request field plus 1.
- R3: In a prefetchable transaction, `deliver_en` stays low until the fill count has reached the initial-threshold field plus 1, or until all initially requested lines have arrived. It rises on the cycle after that condition holds.
- R4: During delivery, a subsequent request is issued when all of these hold: the fill count is at or below the subsequent-threshold field plus 1, no requested lines are still outstanding, and the delay counter is zero. Its size is the subsequent-request field plus 1 lines, and `req_valid` is high for a single cycle.
- R5: Issuing a subsequent request loads a delay D = {3'b111, subsequent-request field}. The next subsequent request appears no sooner than D+1 cycles later.
- R6: With `txn_pref`=0, exactly one line is requested. `txn_done` pulses on the cycle after that line is drained by `line_out`.
- R7: After a single-line read completes, no further request is issued until a new `txn_start`.
- R8: `spd66` (1 = 66 MHz register, 0 = 33 MHz register) is sampled only when a transaction starts. Changing it mid-transaction does not change that transaction's request sizes.
- R9: `abort` clears the fill count, the outstanding count and the delay counter, and returns the block to idle. A transaction started right after an abort issues its initial request at once.
- R10: The fill count saturates at BUF_LINES (24 by default). Each request is trimmed so that it does not exceed the free space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Parameter register write strobe |
| cfg_sel | input | 1 | Register select: 0 = 33 MHz, 1 = 66 MHz |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| spd66 | input | 1 | Bus speed select, sampled at transaction start |
| txn_start | input | 1 | Start of a delayed read transaction |
| txn_pref | input | 1 | 1 = prefetchable read, 0 = plain memory read (one line) |
| abort | input | 1 | Flush and return to idle |
| line_in | input | 1 | One cache line arrived from upstream |
| line_out | input | 1 | PCI master drained one cache line |
| req_valid | output | 1 | Request pulse |
| req_lines | output | 5 | Number of lines requested |
| deliver_en | output | 1 | Delivery to the PCI master enabled |
| txn_done | output | 1 | Single-line read completed |
| fill_cnt | output | FW (5) | Lines currently held in the buffer |

## Verification
The hardest condition to reach is the second subsequent request, because it only shows the pacing delay. By then the first subsequent request's lines must all have arrived, and the fill must have dropped back to the subsequent threshold while the delay counter is still running. The stimulus does this inside one counted loop. The loop feeds the outstanding lines and drains the same number, then counts edges until the next request. The count must equal D+1.

The trimmed request is reached differently. The sizes are reprogrammed so that a sixteen-line subsequent request would overrun the 24-line buffer.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef struct packed {
    logic [3:0] ts;  // subsequent threshold
    logic [3:0] rs;  // subsequent request
    logic [3:0] ti;  // initial threshold
    logic [3:0] ri;  // initial request
  } pf_param_t;

  localparam logic [15:0] PAR33_RST = 16'h1212;
  localparam logic [15:0] PAR66_RST = 16'h3323;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DLV, S_ONE} pf_state_e;

  // 0-based field to line count
  function automatic logic [4:0] lines_of(input logic [3:0] f);
    return {1'b0, f} + 5'd1;
  endfunction

  // pacing delay: three ones above the request field
  function automatic logic [6:0] delay_of(input logic [3:0] rs);
    return {3'b111, rs};
  endfunction
endpackage

// File: rtl/pf_param_regs.sv
module pf_param_regs
  import pf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        spd66,
  output pf_param_t   par_live
);
  logic [15:0] r33, r66;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r33 <= PAR33_RST;
      r66 <= PAR66_RST;
    end else if (cfg_we) begin
      if (cfg_sel) r66 <= cfg_wdata;
      else         r33 <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_sel ? r66 : r33;
  assign par_live  = spd66 ? pf_param_t'(r66) : pf_param_t'(r33);
endmodule

// File: rtl/pf_fill_ctr.sv
module pf_fill_ctr #(
  parameter int FW = 5,
  parameter logic [FW-1:0] CAP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          line_in,
  input  logic          line_out,
  input  logic          issue,
  input  logic [FW-1:0] issue_lines,
  output logic [FW-1:0] fill,
  output logic [FW-1:0] pend
);
  logic inc, dec;
  assign inc = line_in && (fill < CAP);
  assign dec = line_out && (fill != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      pend <= '0;
    end else if (clr) begin
      fill <= '0;
      pend <= '0;
    end else begin
      fill <= fill + FW'(inc) - FW'(dec);
      if (issue)                        pend <= issue_lines;
      else if (line_in && pend != '0)   pend <= pend - 1'b1;
    end
  end
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int FW = 5,
  parameter logic [FW-1:0] CAP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          txn_start,
  input  logic          txn_pref,
  input  logic          line_out,
  input  pf_param_t     par_live,
  input  logic [FW-1:0] fill,
  input  logic [FW-1:0] pend,
  output logic          issue,
  output logic [FW-1:0] issue_lines,
  output logic          req_valid,
  output logic [4:0]    req_lines,
  output logic          req_sub,
  output logic          deliver_en,
  output logic          txn_done,
  output logic          one_mode,
  output logic [FW-1:0] thr,
  output logic [6:0]    dly_d
);
  pf_state_e st;
  pf_param_t lat;
  logic [6:0] dly;
  logic [FW-1:0] room, init_want, sub_want;
  logic issue_init, issue_sub;

  function automatic logic [FW-1:0] fit(input logic [FW-1:0] want,
                                        input logic [FW-1:0] free);
    return (want < free) ? want : free;
  endfunction

  assign room       = CAP - fill;
  assign init_want  = txn_pref ? FW'(lines_of(par_live.ri)) : FW'(1);
  assign sub_want   = FW'(lines_of(lat.rs));
  assign issue_init = !abort && st == S_IDLE && txn_start;
  assign issue_sub  = !abort && st == S_DLV && pend == '0 && dly == '0 &&
                      fill <= FW'(lines_of(lat.ts)) && room != '0;
  assign issue       = issue_init || issue_sub;
  assign issue_lines = issue_init ? fit(init_want, room) : fit(sub_want, room);

  assign thr        = FW'(lines_of(lat.ti));
  assign dly_d      = delay_of(lat.rs);
  assign deliver_en = (st == S_DLV);
  assign one_mode   = (st == S_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lat       <= '0;
      dly       <= '0;
      req_valid <= 1'b0;
      req_lines <= '0;
      req_sub   <= 1'b0;
      txn_done  <= 1'b0;
    end else begin
      req_valid <= issue;
      req_lines <= 5'(issue_lines);
      req_sub   <= issue_sub;
      txn_done  <= 1'b0;
      if (abort) begin
        st  <= S_IDLE;
        dly <= '0;
      end else begin
        if (issue_sub)       dly <= delay_of(lat.rs);
        else if (dly != '0)  dly <= dly - 1'b1;
        case (st)
          S_IDLE: if (txn_start) begin
            lat <= par_live;
            st  <= txn_pref ? S_WAIT : S_ONE;
          end
          S_WAIT: if (fill >= thr || pend == '0) st <= S_DLV;
          S_ONE: if (line_out && fill != '0) begin
            st       <= S_IDLE;
            txn_done <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pf_sched.sv
module pf_sched
  import pf_pkg::*;
#(
  parameter int BUF_LINES = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        spd66,
  input  logic        txn_start,
  input  logic        txn_pref,
  input  logic        abort,
  input  logic        line_in,
  input  logic        line_out,
  output logic        req_valid,
  output logic [4:0]  req_lines,
  output logic        deliver_en,
  output logic        txn_done,
  output logic [((($clog2(BUF_LINES+1)) > 5) ? $clog2(BUF_LINES+1) : 5)-1:0] fill_cnt
);
  localparam int FW0 = $clog2(BUF_LINES + 1);
  localparam int FW  = (FW0 > 5) ? FW0 : 5;
  localparam logic [FW-1:0] CAP = FW'(BUF_LINES);

  pf_param_t     par_w;
  logic          issue_w, req_sub_w, one_w;
  logic [FW-1:0] issue_lines_w, pend_w, thr_w;
  logic [6:0]    dly_w;

  pf_param_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cfg_rdata, .spd66,
    .par_live(par_w)
  );

  pf_fill_ctr #(.FW(FW), .CAP(CAP)) u_fill (
    .clk, .rst_n, .clr(abort), .line_in, .line_out,
    .issue(issue_w), .issue_lines(issue_lines_w),
    .fill(fill_cnt), .pend(pend_w)
  );

  pf_ctrl #(.FW(FW), .CAP(CAP)) u_ctrl (
    .clk, .rst_n, .abort, .txn_start, .txn_pref, .line_out,
    .par_live(par_w), .fill(fill_cnt), .pend(pend_w),
    .issue(issue_w), .issue_lines(issue_lines_w),
    .req_valid, .req_lines, .req_sub(req_sub_w), .deliver_en, .txn_done,
    .one_mode(one_w), .thr(thr_w), .dly_d(dly_w)
  );
endmodule

// File: rtl/pf_sched_chk.sv
module pf_sched_chk #(
  parameter int FW = 5,
  parameter logic [FW-1:0] CAP = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort,
  input logic          req_valid,
  input logic [4:0]    req_lines,
  input logic          deliver_en,
  input logic [FW-1:0] fill_cnt,
  input logic [FW-1:0] pend,
  input logic          req_sub,
  input logic          one_mode,
  input logic [FW-1:0] thr,
  input logic [6:0]    dly_d
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (abort || (req_valid && !req_sub)) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (req_valid && req_sub) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  assert_fill_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CAP);
  assert_req_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(fill_cnt) <= CAP - FW'(req_lines)));
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (fill_cnt == '0 && !deliver_en && !req_valid));
  assert_deliver_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deliver_en) |-> ($past(fill_cnt) >= thr || $past(pend) == '0));
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  assert_sub_pace_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sub && seen) |-> (gap >= {1'b0, dly_d}));
  assert_single_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && one_mode) |-> req_lines == 5'd1);
endmodule

bind pf_sched pf_sched_chk #(.FW(FW), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .req_valid(req_valid),
  .req_lines(req_lines), .deliver_en(deliver_en), .fill_cnt(fill_cnt),
  .pend(pend_w), .req_sub(req_sub_w), .one_mode(one_w), .thr(thr_w),
  .dly_d(dly_w)
);

// File: tb/sim_pf_sched.sv
module sim_pf_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0, spd66 = 0, txn_start = 0, txn_pref = 0;
  logic abort = 0, line_in = 0, line_out = 0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic req_valid, deliver_en, txn_done;
  logic [4:0] req_lines;
  logic [4:0] fill_cnt;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pf_sched u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flush();
    abort = 1; tick(); abort = 0; tick();
  endtask

  task automatic feed(int n);
    for (int i = 0; i < n; i++) begin line_in = 1; tick(); line_in = 0; end
  endtask

  // wait for a request; returns edges waited, -1 if none
  task automatic wait_req(int lim, output int n);
    n = -1;
    for (int i = 0; i < lim; i++) begin
      tick();
      if (req_valid) begin n = i + 1; break; end
    end
  endtask

  task automatic t_reset();
    check("R1 33MHz reset", cfg_rdata, 16'h1212);
    cfg_sel = 1; #1;
    check("R1 66MHz reset", cfg_rdata, 16'h3323);
    cfg_sel = 0;
    check("R9 reset fill", fill_cnt, 0);
    check("R2 no req at reset", req_valid, 0);
  endtask

  task automatic t_single();
    txn_pref = 0; txn_start = 1; tick(); txn_start = 0;
    check("R6 single req", req_valid, 1);
    check("R6 single lines", req_lines, 1);
    feed(1);
    check("R6 fill one", fill_cnt, 1);
    line_out = 1; tick(); line_out = 0;
    check("R6 done pulse", txn_done, 1);
    check("R6 drained", fill_cnt, 0);
    begin
      int n;
      wait_req(30, n);
      check("R7 no refetch", n, -1);
    end
  endtask

  task automatic t_prefetch33();
    int n;
    flush();
    spd66 = 0; txn_pref = 1; txn_start = 1; tick(); txn_start = 0;
    check("R2 initial req", req_valid, 1);
    check("R2 initial lines", req_lines, 3);
    feed(1); tick();
    check("R3 held below threshold", deliver_en, 0);
    feed(1); tick();
    check("R3 deliver at threshold", deliver_en, 1);
    feed(1);
    wait_req(5, n);
    check("R4 no req above threshold", n, -1);
    line_out = 1; tick(); line_out = 0;
    wait_req(3, n);
    check("R4 sub req timing", n, 1);
    check("R4 sub lines", req_lines, 3);
    n = -1;
    for (int i = 0; i < 300; i++) begin
      line_in  = (i < 3);
      line_out = (i >= 3 && i < 6);
      tick();
      line_in = 0; line_out = 0;
      if (req_valid) begin n = i + 1; break; end
    end
    check("R5 paced gap D+1", n, 115);
    flush();
  endtask

  task automatic t_speed();
    int n;
    spd66 = 1; txn_pref = 1; txn_start = 1; tick(); txn_start = 0;
    spd66 = 0;
    check("R8 66MHz initial lines", req_lines, 4);
    feed(4);
    wait_req(10, n);
    check("R8 sub req seen", n > 0, 1);
    check("R8 sub uses latched 66MHz", req_lines, 4);
    flush();
  endtask

  task automatic t_trim();
    int n;
    cfg_sel = 0; cfg_wdata = 16'hFF0F; cfg_we = 1; tick(); cfg_we = 0;
    check("R1 write readback", cfg_rdata, 16'hFF0F);
    txn_pref = 1; txn_start = 1; tick(); txn_start = 0;
    check("R2 sixteen lines", req_lines, 16);
    feed(16);
    wait_req(5, n);
    check("R10 trimmed req seen", n > 0, 1);
    check("R10 trimmed lines", req_lines, 8);
    feed(10);
    check("R10 saturate", fill_cnt, 24);
    flush();
    check("R9 fill cleared", fill_cnt, 0);
    check("R9 deliver off", deliver_en, 0);
    txn_start = 1; tick(); txn_start = 0;
    check("R9 restart issues at once", req_valid, 1);
    flush();
  endtask

  initial begin
    #((8 * 200000));
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_single();
    t_prefetch33();
    t_speed();
    t_trim();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule